// File: doc/BRIEF.md
# ADC Trigger Chain Sequencer

This block turns one accepted trigger into a timed series of conversion requests for an analog-to-digital converter. Each trigger group holds its own chain programme. The programme sets the chain length (one to eight segments), an initial delay, a gap delay, and for each segment the converter channel, a one-hot select of the converter's command register, a pacing choice and an interrupt route. When a grant names a group, the sequencer waits the initial delay. It then issues the segments in order and stores every returned result under its group and segment index. Between segments it either waits the gap delay or, for back-to-back segments, continues as soon as the conversion finishes.

All delays count ticks of a shared pre-divider. The pre-divider produces one tick every pre_div+1 clocks and restarts at the start of each wait, so a delay value D lasts exactly (D+1)·(pre_div+1) clocks. Completed segments can raise one of three done flags. A grant that arrives while a chain is running raises an error flag. Software clears the flags by writing a mask. Arbitration between trigger sources, the converter itself and any data-movement engine sit outside the block.

Top module: `adc_chain_seq`

## Requirements
- R1: After reset the block is idle: busy, conv_req and chain_done are 0 and status reads 0.
- R2: A grant accepted in idle produces its first conv_req exactly (init+1)·(pre_div+1) clocks after the clock edge that samples the grant. The pre-divider is 8 bits, and an init value of 0 still costs one tick.
- R3: After a segment whose pacing bit is 0, the next conv_req comes exactly (gap+1)·(pre_div+1) clocks after the edge that samples conv_done.
- R4: After a segment whose pacing bit is 1 (back-to-back), the next conv_req comes in the clock right after the edge that samples conv_done.
- R5: A group whose 3-bit length field holds L runs exactly L+1 segments. After the last conversion completes, chain_done pulses for one clock, and in that same clock busy is 0.
- R6: While conv_req is high, conv_ch and conv_hc carry the current segment's 5-bit channel and 3-bit one-hot register select (1, 2 or 4 for registers 0, 1, 2).
- R7: A segment's 2-bit interrupt code sets a status bit when its conversion completes: 1 sets bit 0, 2 sets bit 1, 3 sets bit 2, and 0 sets nothing.
- R8: Each bit written as 1 in clr_mask clears the matching status bit. A flag being set in the same clock wins over a clear.
- R9: A grant while busy sets status bit 3 and is otherwise ignored: the running chain keeps its group, timing and outputs.
- R10: Each result is stored at (group, segment) and appears on rd_data in the same clock that rd_grp and rd_seg select it.
- R11: conv_done while the sequencer is not waiting for a conversion changes no stored result and no status bit.
- R12: conv_req is a single-clock pulse per segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_div | input | 8 | Tick divider; one tick per pre_div+1 clocks |
| grant_valid | input | 1 | Start request for the group on grant_grp |
| grant_grp | input | 2 | Granted trigger group |
| cfg_len | input | 12 | Per group, 3-bit length field (segments minus one) |
| cfg_init_dly | input | 32 | Per group, 8-bit initial delay in ticks |
| cfg_gap_dly | input | 32 | Per group, 8-bit gap delay in ticks |
| cfg_b2b | input | 32 | Per group and segment, back-to-back pacing bit |
| cfg_ch | input | 160 | Per group and segment, 5-bit channel |
| cfg_hc | input | 96 | Per group and segment, 3-bit one-hot register select |
| cfg_irq | input | 64 | Per group and segment, 2-bit interrupt code |
| conv_req | output | 1 | Conversion request pulse |
| conv_ch | output | 5 | Channel for the current request |
| conv_hc | output | 3 | One-hot register select for the current request |
| conv_done | input | 1 | Conversion complete |
| conv_result | input | 12 | Conversion result, valid with conv_done |
| status | output | 4 | Flags: bits 0 to 2 are done lines, bit 3 is the error flag |
| clr_mask | input | 4 | Write-1-to-clear mask for status |
| busy | output | 1 | A chain is in progress |
| chain_done | output | 1 | One-clock pulse at chain end |
| rd_grp | input | 2 | Result read group |
| rd_seg | input | 3 | Result read segment |
| rd_data | output | 12 | Selected stored result |

## Verification
Two events can land in the same clock. A clear of a done flag can coincide with the completion that sets that flag, and a clear of the error flag can coincide with a colliding grant. The bench drives clr_mask with all done bits in the very clock that presents conv_done for a chain's last segment. It then expects the routed bit to survive and the other bits to drop. A stray grant is injected in the first wait clock of some chains. The bench then checks that the error bit rises while every request time, channel and stored result matches the unperturbed arithmetic prediction.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_CONV  = 2'd3
  } seq_state_e;

  // interrupt code to done-line mask: 0 none, 1..3 line 0..2
  function automatic logic [2:0] irq_to_mask(input logic [1:0] code);
    logic [2:0] m;
    case (code)
      2'd1:    m = 3'b001;
      2'd2:    m = 3'b010;
      2'd3:    m = 3'b100;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

  // flag register update: set beats clear
  function automatic logic [3:0] flag_next(input logic [3:0] cur,
                                           input logic [3:0] clr,
                                           input logic [3:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/seq_tick_div.sv
module seq_tick_div #(
  parameter int PDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PDIV_W-1:0] pdiv,
  output logic              tick
);
  logic [PDIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart)      cnt <= '0;
    else if (cnt == pdiv)  cnt <= '0;
    else                   cnt <= cnt + PDIV_W'(1);
  end

  assign tick = (cnt == pdiv) && !restart;

  // a tick never follows another tick unless the divider is 0
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pdiv != '0 && $stable(pdiv)) |=> !tick);
endmodule

// File: rtl/seq_status_reg.sv
module seq_status_reg
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] set_vec,
  input  logic [3:0] clr_vec,
  output logic [3:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_next(flags, clr_vec, set_vec);
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/seq_result_store.sv
module seq_result_store #(
  parameter int NG    = 4,
  parameter int MS    = 8,
  parameter int RES_W = 12,
  localparam int GW   = (NG > 1) ? $clog2(NG) : 1,
  localparam int SW   = (MS > 1) ? $clog2(MS) : 1,
  localparam int NE   = NG * MS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [GW-1:0]    wr_grp,
  input  logic [SW-1:0]    wr_seg,
  input  logic [RES_W-1:0] wr_data,
  input  logic [GW-1:0]    rd_grp,
  input  logic [SW-1:0]    rd_seg,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] mem [NE];
  logic [GW+SW-1:0] wr_idx, rd_idx;

  assign wr_idx  = {wr_grp, wr_seg};
  assign rd_idx  = {rd_grp, rd_seg};
  assign rd_data = mem[rd_idx];

  for (genvar i = 0; i < NE; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mem[i] <= '0;
      else if (wr_en && wr_idx == (GW+SW)'(i))    mem[i] <= wr_data;
    end
  end

  assert_store_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/adc_chain_seq.sv
module adc_chain_seq
  import adc_seq_pkg::*;
#(
  parameter int NG     = 4,
  parameter int MS     = 8,
  parameter int CH_W   = 5,
  parameter int RES_W  = 12,
  parameter int DLY_W  = 8,
  parameter int PDIV_W = 8,
  localparam int GW    = (NG > 1) ? $clog2(NG) : 1,
  localparam int SW    = (MS > 1) ? $clog2(MS) : 1,
  localparam int HC_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PDIV_W-1:0]       pre_div,
  input  logic                    grant_valid,
  input  logic [GW-1:0]           grant_grp,
  input  logic [NG*SW-1:0]        cfg_len,
  input  logic [NG*DLY_W-1:0]     cfg_init_dly,
  input  logic [NG*DLY_W-1:0]     cfg_gap_dly,
  input  logic [NG*MS-1:0]        cfg_b2b,
  input  logic [NG*MS*CH_W-1:0]   cfg_ch,
  input  logic [NG*MS*HC_W-1:0]   cfg_hc,
  input  logic [NG*MS*2-1:0]      cfg_irq,
  output logic                    conv_req,
  output logic [CH_W-1:0]         conv_ch,
  output logic [HC_W-1:0]         conv_hc,
  input  logic                    conv_done,
  input  logic [RES_W-1:0]        conv_result,
  output logic [3:0]              status,
  input  logic [3:0]              clr_mask,
  output logic                    busy,
  output logic                    chain_done,
  input  logic [GW-1:0]           rd_grp,
  input  logic [SW-1:0]           rd_seg,
  output logic [RES_W-1:0]        rd_data
);
  seq_state_e        state;
  logic [GW-1:0]     grp;
  logic [SW-1:0]     seg;
  logic [DLY_W-1:0]  dcnt;
  logic              done_q;

  // named internal events
  logic              tick;
  logic              accept;
  logic              collide;
  logic              seg_fin;
  logic              last_seg;
  logic              go_gap;
  logic              restart;
  logic [GW+SW-1:0]  sidx;
  logic              cur_b2b;
  logic [2:0]        done_set;

  assign sidx     = {grp, seg};
  assign accept   = grant_valid && (state == ST_IDLE);
  assign collide  = grant_valid && (state != ST_IDLE);
  assign seg_fin  = conv_done && (state == ST_CONV);
  assign last_seg = (seg == cfg_len[grp*SW +: SW]);
  assign cur_b2b  = cfg_b2b[sidx];
  assign go_gap   = seg_fin && !last_seg && !cur_b2b;
  assign restart  = accept || go_gap;
  assign done_set = seg_fin ? irq_to_mask(cfg_irq[sidx*2 +: 2]) : 3'b000;

  seq_tick_div #(.PDIV_W(PDIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .pdiv    (pre_div),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      grp    <= '0;
      seg    <= '0;
      dcnt   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= seg_fin && last_seg;
      case (state)
        ST_IDLE: if (accept) begin
          grp   <= grant_grp;
          seg   <= '0;
          dcnt  <= cfg_init_dly[grant_grp*DLY_W +: DLY_W];
          state <= ST_WAIT;
        end
        ST_WAIT: if (tick) begin
          if (dcnt == '0) state <= ST_ISSUE;
          else            dcnt  <= dcnt - DLY_W'(1);
        end
        ST_ISSUE: state <= ST_CONV;
        ST_CONV: if (seg_fin) begin
          if (last_seg) begin
            state <= ST_IDLE;
          end else begin
            seg <= seg + SW'(1);
            if (cur_b2b) begin
              state <= ST_ISSUE;
            end else begin
              dcnt  <= cfg_gap_dly[grp*DLY_W +: DLY_W];
              state <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign conv_req   = (state == ST_ISSUE);
  assign conv_ch    = cfg_ch[sidx*CH_W +: CH_W];
  assign conv_hc    = cfg_hc[sidx*HC_W +: HC_W];
  assign busy       = (state != ST_IDLE);
  assign chain_done = done_q;

  seq_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec ({collide, done_set}),
    .clr_vec (clr_mask),
    .flags   (status)
  );

  seq_result_store #(.NG(NG), .MS(MS), .RES_W(RES_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_fin),
    .wr_grp  (grp),
    .wr_seg  (seg),
    .wr_data (conv_result),
    .rd_grp  (rd_grp),
    .rd_seg  (rd_seg),
    .rd_data (rd_data)
  );

  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  assert_idle_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy);

  assert_collision_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && busy) |=> status[3]);

  assert_collision_keeps_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && busy) |=> (grp == $past(grp)));

  assert_stray_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && state != ST_CONV && clr_mask == 4'd0) |=> (status[2:0] == $past(status[2:0])));
endmodule

// File: tb/adc_chain_seq_tb.sv
module adc_chain_seq_tb;
  localparam int NG = 4, MS = 8, CH_W = 5, RES_W = 12, DLY_W = 8, LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]            pre_div = '0;
  logic                  grant_valid = 1'b0;
  logic [1:0]            grant_grp = '0;
  logic [NG*3-1:0]       cfg_len;
  logic [NG*DLY_W-1:0]   cfg_init_dly, cfg_gap_dly;
  logic [NG*MS-1:0]      cfg_b2b;
  logic [NG*MS*CH_W-1:0] cfg_ch;
  logic [NG*MS*3-1:0]    cfg_hc;
  logic [NG*MS*2-1:0]    cfg_irq;
  logic                  conv_req, conv_done = 1'b0, busy, chain_done;
  logic [CH_W-1:0]       conv_ch;
  logic [2:0]            conv_hc;
  logic [RES_W-1:0]      conv_result = '0, rd_data;
  logic [3:0]            status, clr_mask = '0;
  logic [1:0]            rd_grp = '0;
  logic [2:0]            rd_seg = '0;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  int blen [NG];
  logic [3:0] exp_st;

  always #10 clk = ~clk;

  adc_chain_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pre_div(pre_div), .grant_valid(grant_valid),
    .grant_grp(grant_grp), .cfg_len(cfg_len), .cfg_init_dly(cfg_init_dly),
    .cfg_gap_dly(cfg_gap_dly), .cfg_b2b(cfg_b2b), .cfg_ch(cfg_ch), .cfg_hc(cfg_hc),
    .cfg_irq(cfg_irq), .conv_req(conv_req), .conv_ch(conv_ch), .conv_hc(conv_hc),
    .conv_done(conv_done), .conv_result(conv_result), .status(status),
    .clr_mask(clr_mask), .busy(busy), .chain_done(chain_done),
    .rd_grp(rd_grp), .rd_seg(rd_seg), .rd_data(rd_data)
  );

  function automatic int init_of(int g); return g % 3; endfunction
  function automatic int gap_of(int g);  return (g + 1) % 3; endfunction
  function automatic bit b2b_of(int g, int s); return ((g + s) % 3) == 0; endfunction
  function automatic int ch_of(int g, int s);  return (g * 8 + s * 3) % 32; endfunction
  function automatic int hc_of(int g, int s);  return 1 << ((g + s) % 3); endfunction
  function automatic int irq_of(int g, int s); return (g + 2 * s) % 4; endfunction
  function automatic int res_of(int g, int s, int p); return (g * 97 + s * 13 + p * 41 + 5) % 4096; endfunction
  function automatic logic [3:0] line_of(int code);
    return (code == 0) ? 4'd0 : 4'(1 << (code - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic load_cfg();
    for (int g = 0; g < NG; g++) begin
      cfg_len[g*3 +: 3]            = 3'(blen[g]);
      cfg_init_dly[g*DLY_W +: DLY_W] = 8'(init_of(g));
      cfg_gap_dly[g*DLY_W +: DLY_W]  = 8'(gap_of(g));
      for (int s = 0; s < MS; s++) begin
        cfg_b2b[g*MS + s]               = b2b_of(g, s);
        cfg_ch[(g*MS + s)*CH_W +: CH_W] = 5'(ch_of(g, s));
        cfg_hc[(g*MS + s)*3 +: 3]       = 3'(hc_of(g, s));
        cfg_irq[(g*MS + s)*2 +: 2]      = 2'(irq_of(g, s));
      end
    end
  endtask

  task automatic run_chain(input int g, input bit inject, input bit clr_same);
    int w, p;
    bit early;
    p = int'(pre_div);
    exp_st = status;
    @(negedge clk);
    grant_valid = 1'b1; grant_grp = 2'(g);
    @(negedge clk);
    grant_valid = 1'b0;
    chk(busy == 1'b1, "R5 busy after grant", busy, 1);
    w = (init_of(g) + 1) * (p + 1);
    for (int s = 0; s <= blen[g]; s++) begin
      early = 0;
      for (int n = 0; n < w; n++) begin
        if (conv_req || chain_done) early = 1;
        if (inject && s == 0 && n == 0) begin
          grant_valid = 1'b1; grant_grp = 2'((g + 1) % NG);
          exp_st[3] = 1'b1;
        end
        @(negedge clk);
        grant_valid = 1'b0;
      end
      chk(!early, (s == 0) ? "R2 no early request" :
                  (b2b_of(g, s-1) ? "R4 no early request" : "R3 no early request"), early, 0);
      chk(conv_req == 1'b1, (s == 0) ? "R2 request timing" :
                  (b2b_of(g, s-1) ? "R4 request timing" : "R3 request timing"), conv_req, 1);
      chk(conv_ch == 5'(ch_of(g, s)), "R6 channel", conv_ch, ch_of(g, s));
      chk(conv_hc == 3'(hc_of(g, s)), "R6 register select", conv_hc, hc_of(g, s));
      @(negedge clk);
      chk(conv_req == 1'b0, "R12 single pulse", conv_req, 0);
      repeat (LAT - 1) @(negedge clk);
      conv_done = 1'b1;
      conv_result = 12'(res_of(g, s, p));
      if (clr_same && s == blen[g]) clr_mask = 4'b0111;
      @(negedge clk);
      exp_st = (exp_st & ~clr_mask) | line_of(irq_of(g, s));
      conv_done = 1'b0;
      clr_mask = 4'b0000;
      chk(status == exp_st, clr_same && s == blen[g] ? "R8 set beats clear" : "R7 done routing",
          status, exp_st);
      if (s == blen[g]) begin
        chk(chain_done == 1'b1, "R5 chain end pulse", chain_done, 1);
        chk(busy == 1'b0, "R5 idle at end", busy, 0);
        @(negedge clk);
        chk(chain_done == 1'b0, "R5 pulse width", chain_done, 0);
      end else begin
        chk(chain_done == 1'b0, "R5 not yet done", chain_done, 0);
      end
      w = b2b_of(g, s) ? 0 : (gap_of(g) + 1) * (p + 1);
    end
    for (int s = 0; s <= blen[g]; s++) begin
      rd_grp = 2'(g); rd_seg = 3'(s);
      #1;
      chk(rd_data == 12'(res_of(g, s, p)), "R10 readback", rd_data, res_of(g, s, p));
    end
    @(negedge clk);
    clr_mask = 4'b1111;
    @(negedge clk);
    clr_mask = 4'b0000;
    chk(status == 4'd0, "R8 mask clear", status, 0);
  endtask

  initial begin
    for (int g = 0; g < NG; g++) blen[g] = (g * 3 + 1) % 8;
    load_cfg();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && conv_req == 1'b0 && chain_done == 1'b0, "R1 idle outputs",
        {busy, conv_req, chain_done}, 0);
    chk(status == 4'd0, "R1 status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 4'd0 && busy == 1'b0, "R1 after release", status, 0);

    for (int p = 0; p < 3; p++) begin
      pre_div = 8'(p);
      for (int g = 0; g < NG; g++) run_chain(g, g == 1, g == 2 || g == 3);
    end

    // single-segment chain from a zero length field
    blen[0] = 0;
    load_cfg();
    pre_div = 8'd4;
    run_chain(0, 1'b0, 1'b0);

    // full-length chain with a large divider
    blen[2] = 7;
    load_cfg();
    pre_div = 8'd9;
    run_chain(2, 1'b1, 1'b0);

    // R11: stray completion while idle
    @(negedge clk);
    conv_done = 1'b1; conv_result = 12'hABC;
    @(negedge clk);
    conv_done = 1'b0;
    chk(status == 4'd0, "R11 stray done status", status, 0);
    chk(conv_req == 1'b0 && busy == 1'b0, "R11 stays idle", busy, 0);
    rd_grp = 2'd0; rd_seg = 3'd0;
    #1;
    chk(rd_data == 12'(res_of(0, 0, 4)), "R11 store untouched", rd_data, res_of(0, 0, 4));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule